// File: doc/BRIEF.md
# FIFO Retransmit Setup Sequencer

This block controls the rewind of a dual-clock FIFO to its first stored word. A rewind request is sampled on the read clock. When it is accepted, the block pulses a pointer-rewind command to the neighbouring FIFO core and takes the read-side availability indication away. It then runs a timed setup of fixed length and hands back availability at the end. In fall-through mode the setup is one read cycle longer, and on its final edge the block tells the core to load the first stored word into the output register without any read enable.

The block also tells the core when to refresh its status flags. Half-full is refreshed on the final setup edge. Almost-empty is refreshed two read edges later. Almost-full is refreshed after the completion has crossed into the write domain. On the write side, a write-permit output closes while a setup runs. It reopens when the setup finishes or when a window of a fixed number of faster-clock cycles has elapsed, whichever happens first. A parameter selects the clock domain in which that window is counted. The storage array, the pointer synchronizers and the flag offsets belong to the core.

Top module: `rt_setup_seq`

## Requirements
- R1: When `rt_req` is high on a read-clock rising edge while no setup runs, that edge starts a setup. `rewind` is high in the cycle before that edge. After the edge `setup_busy` is 1 and `rd_avail` is 0.
- R2: The setup ends on the STD_SETUP-th read edge after its start edge (default 16) in standard mode, and on the (STD_SETUP+1)-th edge in fall-through mode. `rd_avail` is 1 and `setup_busy` is 0 after that edge.
- R3: `load_first` is 1 only in the cycle before the final setup edge, and only in fall-through mode. It stays 0 in standard mode.
- R4: `hf_upd` is 1 only in the cycle before the final setup edge. `ae_upd` is 1 only in the cycle before the second read edge after the final setup edge.
- R5: `af_upd` is a pulse one write cycle wide, sampled by the second write edge after the final setup edge. With AF_EXTRA_EDGE=1 it is sampled by the third write edge instead.
- R6: When the window is counted on the write clock, `wr_permit` goes to 0 after the third write edge following the start edge. It returns to 1 after WIN_CYC (default 14) further write edges, or earlier if the completion of the setup arrives in the write domain first. Outside that span `wr_permit` is 1.
- R7: A request that is high during a setup is ignored, including on the final setup edge. `rewind` stays 0 and the setup ends on schedule. No new setup starts unless the request is sampled high again after the final edge.
- R8: `rd_accept` is 1 exactly when `rd_en` and `rd_avail` are 1 and no setup runs. It is therefore 0 throughout a setup.
- R9: The mode is captured from `fwft_sel` on read edges while `rst_n` is low (1 selects fall-through). Changes to `fwft_sel` after reset have no effect.
- R10: During reset `rd_avail`, `setup_busy`, `rewind`, `load_first`, `hf_upd`, `ae_upd` and `af_upd` are 0 and `wr_permit` is 1. Outside a setup, `rd_avail` follows `core_avail` one read edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read clock |
| wr_clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Mode select, captured during reset (1 = fall-through) |
| rt_req | input | 1 | Rewind request, sampled on the read clock |
| rd_en | input | 1 | Read enable from the consumer |
| core_avail | input | 1 | Availability reported by the FIFO core outside a setup |
| rewind | output | 1 | Pointer-rewind command, valid for the accepting read edge |
| load_first | output | 1 | Load-first-word command for the final setup edge |
| rd_avail | output | 1 | Output-ready / not-empty indication to the consumer |
| rd_accept | output | 1 | Gated read strobe to the core |
| setup_busy | output | 1 | A setup is in progress |
| hf_upd | output | 1 | Half-full refresh strobe (read domain) |
| ae_upd | output | 1 | Almost-empty refresh strobe (read domain) |
| af_upd | output | 1 | Almost-full refresh strobe (write domain) |
| wr_permit | output | 1 | Writes allowed (write domain) |

## Verification
Two events can fall on the final setup edge together: the completion of the setup and a fresh rewind request. A read enable can also be present on that edge. The bench holds `rt_req` and `rd_en` high through the whole setup, including that final edge, and drops both at the following falling edge. Passing requires all of the following: the setup still ends on its scheduled edge, `rd_accept` never rises during the setup, `rd_avail` stays high on the next read edge instead of restarting, and the almost-empty strobe still appears two edges later.

// File: rtl/rt_setup_pkg.sv
package rt_setup_pkg;

   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_SETUP = 1'b1
   } rt_phase_e;

   // counter width able to hold values 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rt_sync_vec.sv
module rt_sync_vec #(
   parameter int unsigned DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d,
   output logic [DEPTH-1:0] stg
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rt_sync_vec: DEPTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[DEPTH-2:0], d};
   end

endmodule

// File: rtl/rt_rd_seq.sv
module rt_rd_seq
   import rt_setup_pkg::*;
#(
   parameter int unsigned STD_SETUP = 16,
   parameter int unsigned WIN_CYC   = 14,
   parameter bit          WIN_IN_RD = 1'b0
) (
   input  logic rd_clk,
   input  logic rst_n,
   input  logic fwft_sel,
   input  logic rt_req,
   input  logic rd_en,
   input  logic core_avail,
   output logic rewind,
   output logic load_first,
   output logic hf_upd,
   output logic ae_upd,
   output logic rd_avail,
   output logic rd_accept,
   output logic setup_busy,
   output logic start_tgl,
   output logic done_tgl,
   output logic hold_rd
);

   localparam int unsigned FWFT_LEN = STD_SETUP + 1;
   localparam int unsigned CW       = cnt_w(FWFT_LEN);
   localparam int unsigned WW       = cnt_w(WIN_CYC);

   rt_phase_e     phase;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last_len;
   logic          fwft_q;
   logic          start;
   logic          last_edge;
   logic [1:0]    ae_pipe;

   // mode capture while reset is held
   always_ff @(posedge rd_clk) begin
      if (!rst_n) fwft_q <= fwft_sel;
   end

   assign last_len   = fwft_q ? CW'(FWFT_LEN - 1) : CW'(STD_SETUP - 1);
   assign start      = (phase == PH_IDLE) && rt_req;
   assign last_edge  = (phase == PH_SETUP) && (cnt == last_len);
   assign setup_busy = (phase == PH_SETUP);
   assign rewind     = start;
   assign hf_upd     = last_edge;
   assign load_first = last_edge && fwft_q;
   assign ae_upd     = ae_pipe[1];
   assign rd_accept  = rd_en && rd_avail && (phase == PH_IDLE);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         rd_avail  <= 1'b0;
         start_tgl <= 1'b0;
         done_tgl  <= 1'b0;
         ae_pipe   <= '0;
      end else begin
         ae_pipe <= {ae_pipe[0], last_edge};
         if (start) begin
            phase     <= PH_SETUP;
            cnt       <= '0;
            rd_avail  <= 1'b0;
            start_tgl <= ~start_tgl;
         end else if (last_edge) begin
            phase    <= PH_IDLE;
            rd_avail <= 1'b1;
            done_tgl <= ~done_tgl;
         end else if (phase == PH_SETUP) begin
            cnt <= cnt + 1'b1;
         end else begin
            rd_avail <= core_avail;
         end
      end
   end

   // write-permit window counted on the read clock when it is the faster one
   if (WIN_IN_RD) begin : g_win_rd
      logic [WW-1:0] wcnt;
      logic          hold_q;
      always_ff @(posedge rd_clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
            wcnt   <= '0;
         end else if (start) begin
            hold_q <= 1'b1;
            wcnt   <= '0;
         end else if (hold_q) begin
            if (last_edge || (wcnt == WW'(WIN_CYC - 1))) hold_q <= 1'b0;
            wcnt <= wcnt + 1'b1;
         end
      end
      assign hold_rd = hold_q;
   end else begin : g_win_wr
      assign hold_rd = 1'b0;
   end

   a_r1_start: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (phase == PH_IDLE && rt_req) |=> (phase == PH_SETUP && cnt == '0 && !rd_avail));

   a_r7_ignore_req: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (phase == PH_SETUP && !last_edge) |=> (phase == PH_SETUP && cnt == $past(cnt) + 1'b1));

   a_r2_done: assert property (@(posedge rd_clk) disable iff (!rst_n)
      last_edge |=> (phase == PH_IDLE && rd_avail));

   a_r4_ae_lag: assert property (@(posedge rd_clk) disable iff (!rst_n)
      hf_upd |=> ##1 ae_upd);

   a_r8_no_read_in_setup: assert property (@(posedge rd_clk) disable iff (!rst_n)
      setup_busy |-> !rd_accept);

endmodule

// File: rtl/rt_wr_side.sv
module rt_wr_side
   import rt_setup_pkg::*;
#(
   parameter int unsigned WIN_CYC   = 14,
   parameter bit          WIN_IN_RD = 1'b0,
   parameter bit          AF_EXTRA  = 1'b0
) (
   input  logic wr_clk,
   input  logic rst_n,
   input  logic start_tgl,
   input  logic done_tgl,
   input  logic hold_rd,
   output logic wr_permit,
   output logic af_upd
);

   localparam int unsigned SD = 3;
   localparam int unsigned WW = cnt_w(WIN_CYC);

   logic [SD-1:0] s_stg, d_stg, h_stg;
   logic          start_arr, done_arr, hold_fall, cnt_expire;
   logic          hold_q;

   rt_sync_vec #(.DEPTH(SD)) u_sync_start (.clk(wr_clk), .rst_n(rst_n), .d(start_tgl), .stg(s_stg));
   rt_sync_vec #(.DEPTH(SD)) u_sync_done  (.clk(wr_clk), .rst_n(rst_n), .d(done_tgl),  .stg(d_stg));
   rt_sync_vec #(.DEPTH(SD)) u_sync_hold  (.clk(wr_clk), .rst_n(rst_n), .d(hold_rd),   .stg(h_stg));

   assign start_arr = s_stg[2] ^ s_stg[1];
   assign done_arr  = d_stg[2] ^ d_stg[1];
   assign hold_fall = h_stg[2] & ~h_stg[1];

   // strobe timing choice: second or third write edge after completion
   if (AF_EXTRA) begin : g_af_late
      assign af_upd = d_stg[2] ^ d_stg[1];
   end else begin : g_af_early
      assign af_upd = d_stg[1] ^ d_stg[0];
   end

   if (WIN_IN_RD) begin : g_cnt_rd
      assign cnt_expire = 1'b0;
   end else begin : g_cnt_wr
      logic [WW-1:0] wcnt;
      always_ff @(posedge wr_clk or negedge rst_n) begin
         if (!rst_n)         wcnt <= '0;
         else if (start_arr) wcnt <= '0;
         else if (hold_q)    wcnt <= wcnt + 1'b1;
      end
      assign cnt_expire = hold_q && (wcnt == WW'(WIN_CYC - 1));

      a_r6_window_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
         hold_q |-> (wcnt < WW'(WIN_CYC)));
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n)                              hold_q <= 1'b0;
      else if (done_arr || cnt_expire || hold_fall) hold_q <= 1'b0;
      else if (start_arr)                      hold_q <= 1'b1;
   end

   assign wr_permit = ~hold_q;

   a_r5_af_single: assert property (@(posedge wr_clk) disable iff (!rst_n)
      af_upd |=> !af_upd);

   a_r6_reopen_on_done: assert property (@(posedge wr_clk) disable iff (!rst_n)
      done_arr |=> wr_permit);

endmodule

// File: rtl/rt_setup_seq.sv
module rt_setup_seq #(
   parameter int unsigned STD_SETUP      = 16,
   parameter int unsigned WIN_CYC        = 14,
   parameter bit          FAST_CLK_IS_WR = 1'b1,
   parameter bit          AF_EXTRA_EDGE  = 1'b0
) (
   input  logic rd_clk,
   input  logic wr_clk,
   input  logic rst_n,
   input  logic fwft_sel,
   input  logic rt_req,
   input  logic rd_en,
   input  logic core_avail,
   output logic rewind,
   output logic load_first,
   output logic rd_avail,
   output logic rd_accept,
   output logic setup_busy,
   output logic hf_upd,
   output logic ae_upd,
   output logic af_upd,
   output logic wr_permit
);

   localparam bit WIN_IN_RD = !FAST_CLK_IS_WR;

   if (STD_SETUP < 1) begin : g_bad_setup
      $error("rt_setup_seq: STD_SETUP must be at least 1");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("rt_setup_seq: WIN_CYC must be at least 2");
   end

   logic start_tgl, done_tgl, hold_rd;

   rt_rd_seq #(
      .STD_SETUP (STD_SETUP),
      .WIN_CYC   (WIN_CYC),
      .WIN_IN_RD (WIN_IN_RD)
   ) u_rd (
      .rd_clk     (rd_clk),
      .rst_n      (rst_n),
      .fwft_sel   (fwft_sel),
      .rt_req     (rt_req),
      .rd_en      (rd_en),
      .core_avail (core_avail),
      .rewind     (rewind),
      .load_first (load_first),
      .hf_upd     (hf_upd),
      .ae_upd     (ae_upd),
      .rd_avail   (rd_avail),
      .rd_accept  (rd_accept),
      .setup_busy (setup_busy),
      .start_tgl  (start_tgl),
      .done_tgl   (done_tgl),
      .hold_rd    (hold_rd)
   );

   rt_wr_side #(
      .WIN_CYC   (WIN_CYC),
      .WIN_IN_RD (WIN_IN_RD),
      .AF_EXTRA  (AF_EXTRA_EDGE)
   ) u_wr (
      .wr_clk    (wr_clk),
      .rst_n     (rst_n),
      .start_tgl (start_tgl),
      .done_tgl  (done_tgl),
      .hold_rd   (hold_rd),
      .wr_permit (wr_permit),
      .af_upd    (af_upd)
   );

endmodule

// File: tb/rt_setup_seq_test.sv
module rt_setup_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int WR_HALF    = 3;
   localparam int STD_LEN    = 16;
   localparam int WIN        = 14;

   logic rd_clk = 1'b0, wr_clk = 1'b0, rst_n = 1'b0;
   logic fwft_sel = 1'b0, rt_req = 1'b0, rd_en = 1'b0, core_avail = 1'b1;
   logic rewind, load_first, rd_avail, rd_accept, setup_busy;
   logic hf_upd, ae_upd, af_upd, wr_permit;

   int n_vec = 0, n_bad = 0;
   bit last_seen;

   rt_setup_seq uut (
      .rd_clk(rd_clk), .wr_clk(wr_clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
      .rt_req(rt_req), .rd_en(rd_en), .core_avail(core_avail),
      .rewind(rewind), .load_first(load_first), .rd_avail(rd_avail),
      .rd_accept(rd_accept), .setup_busy(setup_busy), .hf_upd(hf_upd),
      .ae_upd(ae_upd), .af_upd(af_upd), .wr_permit(wr_permit)
   );

   always #(CLK_PERIOD/2) rd_clk = ~rd_clk;
   initial begin
      #1;
      forever #(WR_HALF) wr_clk = ~wr_clk;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic mode);
      rst_n    = 1'b0;
      fwft_sel = mode;
      rt_req   = 1'b0;
      rd_en    = 1'b0;
      repeat (4) @(negedge rd_clk);
      chk("R10 reset rd_avail", rd_avail, 0);
      chk("R10 reset busy", setup_busy, 0);
      chk("R10 reset hf/ae/load", {hf_upd, ae_upd, load_first}, 0);
      chk("R10 reset af_upd", af_upd, 0);
      chk("R10 reset wr_permit", wr_permit, 1);
      rst_n = 1'b1;
      @(negedge rd_clk);
      fwft_sel = ~mode;            // R9: must not change the captured mode
      @(negedge rd_clk);
   endtask

   task automatic t_follow;
      core_avail = 1'b0;
      @(negedge rd_clk);
      chk("R10 follow low", rd_avail, 0);
      rd_en = 1'b1;
      #1 chk("R8 no accept when unavailable", rd_accept, 0);
      core_avail = 1'b1;
      @(negedge rd_clk);
      chk("R10 follow high", rd_avail, 1);
      chk("R8 accept when idle and available", rd_accept, 1);
      rd_en = 1'b0;
      #1 chk("R8 no accept without rd_en", rd_accept, 0);
   endtask

   task automatic t_setup(input bit fwft);
      int len;
      len = fwft ? STD_LEN + 1 : STD_LEN;
      last_seen = 1'b0;
      @(negedge rd_clk);
      rt_req = 1'b1;
      rd_en  = 1'b1;
      #1 chk("R1 rewind before start edge", rewind, 1);
      @(posedge rd_clk);           // start edge
      fork
         begin : rd_side
            bit acc_seen, early_avail, hf_bad, ld_bad, rw_bad;
            acc_seen = 0; early_avail = 0; hf_bad = 0; ld_bad = 0; rw_bad = 0;
            @(negedge rd_clk);
            chk("R1 busy after start", setup_busy, 1);
            chk("R1 avail dropped", rd_avail, 0);
            for (int k = 1; k <= len; k++) begin
               if (rd_accept) acc_seen = 1;
               if (rewind) rw_bad = 1;
               if (rd_avail) early_avail = 1;
               if (hf_upd !== (k == len)) hf_bad = 1;
               if (load_first !== (fwft && (k == len))) ld_bad = 1;
               @(posedge rd_clk);
               if (k == len) last_seen = 1'b1;
               @(negedge rd_clk);
            end
            chk("R8 no read during setup", acc_seen, 0);
            chk("R7 no rewind during setup", rw_bad, 0);
            chk("R2 avail stays low until last edge", early_avail, 0);
            chk("R4 hf_upd only before last edge", hf_bad, 0);
            chk("R3 load_first timing for mode", ld_bad, 0);
            chk("R2 avail after last edge", rd_avail, 1);
            chk("R2 busy cleared", setup_busy, 0);
            rt_req = 1'b0;
            rd_en  = 1'b0;
            chk("R4 ae_upd not yet", ae_upd, 0);
            @(negedge rd_clk);
            chk("R4 ae_upd second edge", ae_upd, 1);
            chk("R7 request on last edge ignored", rd_avail, 1);
            chk("R7 no restart", setup_busy, 0);
            @(negedge rd_clk);
            chk("R4 ae_upd one cycle", ae_upd, 0);
         end
         begin : wr_side
            for (int k = 1; k <= WIN + 3; k++) begin
               @(posedge wr_clk);
               @(negedge wr_clk);
               if (k == 2)       chk("R6 permit open before arrival", wr_permit, 1);
               if (k == 3)       chk("R6 permit closed", wr_permit, 0);
               if (k == WIN + 2) chk("R6 permit still closed", wr_permit, 0);
               if (k == WIN + 3) chk("R6 permit reopened by window", wr_permit, 1);
            end
            wait (last_seen);
            chk("R5 af_upd idle at last edge", af_upd, 0);
            @(posedge wr_clk);
            @(negedge wr_clk);
            chk("R5 af_upd before second wr edge", af_upd, 1);
            @(posedge wr_clk);
            @(negedge wr_clk);
            chk("R5 af_upd single cycle", af_upd, 0);
            chk("R6 permit open after setup", wr_permit, 1);
         end
      join
      repeat (3) @(negedge rd_clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      do_reset(1'b0);
      t_follow();
      t_setup(1'b0);               // standard mode, R9 latched despite fwft_sel=1
      t_setup(1'b0);
      do_reset(1'b1);
      t_setup(1'b1);               // fall-through mode, fwft_sel now 0
      t_follow();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule